// File: doc/BRIEF.md
# Two-Wide Register Rename Stage

This block sits between decode and issue in an out-of-order core whose committed and speculative values share one physical register file. It takes a group of up to two decoded instructions each cycle. Each instruction names one architectural destination and two architectural sources. For every instruction that writes a register, the block takes a fresh physical register from a free pool. It looks up both sources in a mapping table and returns the physical register that the destination used to map to. That displaced register travels with the instruction. Commit hands it back to the pool once the instruction retires.

The second instruction of a group is compared against the first within the same cycle. These comparisons run beside the table reads. When the first instruction writes a register that the second one reads or overwrites, the second instruction sees the first one's new physical register and not the table value. A group marked as holding a branch saves a checkpoint of the mapping table. A mispredict on that branch puts the table back in one cycle and returns the registers allocated since the checkpoint.

The group input is a valid/ready stream. A group is accepted on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is combinational and depends on the contents of the offered group, so the sender must hold the group stable until it is accepted. The renamed group appears on the registered output one cycle after acceptance. The output has no back-pressure, so the consumer must take every group. Commit and branch-resolve pins are plain per-cycle strobes.

Top module: `rn_rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i and physical registers 8 to 15 are free. `in_ready` is high for a group that writes nothing and `out_valid` is low. Allocation always takes the lowest-numbered free physical register, with lane 0 served before lane 1.
- R2: A lane writes a register when it is valid, has `in_has_dst` set and names a destination other than 0. Each writing lane in an accepted group receives a distinct free physical register as `out_pdst`. All outputs of the group appear, with `out_valid` high, in the cycle after acceptance.
- R3: Each source returns the physical register that currently holds the newest value of that architectural register.
- R4: `out_pold` of a writing lane is the mapping its destination had before this instruction. A lane that writes nothing reports 0 in both `out_pdst` and `out_pold`. A lane that is not valid reports 0 in all four of its fields, and `out_lane_vld` echoes the lane mask.
- R5: When lane 0 writes register d, any lane 1 source equal to d reads lane 0's new physical register. If lane 1 also writes d, its `out_pold` is lane 0's new register, and the table ends up holding lane 1's register.
- R6: Architectural register 0 is never renamed. A lane that names it as destination gets `out_pdst` 0, consumes no free register and leaves the table unchanged.
- R7: When fewer registers are free than the group's writing lanes need, `in_ready` is low, nothing is renamed and nothing is allocated. A group that writes nothing is still accepted.
- R8: Each `cm_valid` lane returns `cm_pold` to the free pool. The register can be allocated from the next cycle on. Commit is only used for lanes that wrote a register.
- R9: An accepted group with `in_branch` high saves a checkpoint in the lowest-numbered free slot of four. The output reports it with `out_snap_vld` high and the slot number in `out_snap_tag`. The checkpoint holds the table after the group's own writes. A branch group is refused while all four slots are in use.
- R10: When `br_valid` and `br_mispredict` are high, the table is restored from slot `br_tag`, and every register allocated after that checkpoint is freed. That slot and every slot taken after it are released, and `in_ready` is low in that cycle. `br_valid` without `br_mispredict` releases only slot `br_tag`.
- R11: While `in_valid` is high and `in_ready` is low, no output group is produced in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Group offered |
| in_ready | output | 1 | Group can be accepted this cycle |
| in_lane_vld | input | 2 | Per-lane instruction present |
| in_has_dst | input | 2 | Per-lane instruction writes a register |
| in_dst | input | 2x3 | Per-lane architectural destination |
| in_src1 | input | 2x3 | Per-lane first architectural source |
| in_src2 | input | 2x3 | Per-lane second architectural source |
| in_branch | input | 1 | Group ends with a branch; take a checkpoint |
| out_valid | output | 1 | Renamed group present |
| out_lane_vld | output | 2 | Lane mask of the renamed group |
| out_pdst | output | 2x4 | New physical destination per lane |
| out_psrc1 | output | 2x4 | Physical first source per lane |
| out_psrc2 | output | 2x4 | Physical second source per lane |
| out_pold | output | 2x4 | Displaced physical destination per lane |
| out_snap_vld | output | 1 | Group took a checkpoint |
| out_snap_tag | output | 2 | Checkpoint slot taken |
| cm_valid | input | 2 | Per-lane commit strobe |
| cm_pold | input | 2x4 | Physical register freed by commit |
| br_valid | input | 1 | Branch resolved this cycle |
| br_mispredict | input | 1 | Resolved branch was mispredicted |
| br_tag | input | 2 | Checkpoint slot of the resolved branch |

## Verification
The bench builds the block with the default parameters: 8 architectural registers, 16 physical registers and four checkpoint slots. With only eight spare registers, a few groups drain the pool. That makes it cheap to reach the stall, the refill through commit, and the lowest-first allocation order. Four slots let the bench fill every checkpoint and see a branch group refused. It then releases one slot out of order and shows that a mispredict on the oldest checkpoint releases all younger ones.

// File: rtl/rn_pkg.sv
package rn_pkg;
  parameter int ARCH_N = 8;
  parameter int PHYS_N = 16;
  parameter int SNAP_N = 4;
  parameter int LANES  = 2;
  localparam int AW = $clog2(ARCH_N);
  localparam int PW = $clog2(PHYS_N);
  localparam int SW = $clog2(SNAP_N);
  typedef logic [AW-1:0]     areg_t;
  typedef logic [PW-1:0]     preg_t;
  typedef logic [SW-1:0]     stag_t;
  typedef logic [PHYS_N-1:0] pmask_t;
  typedef preg_t [ARCH_N-1:0] map_t;
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list import rn_pkg::*; (
  input  logic           clk,
  input  logic           rst_n,
  input  pmask_t         alloc_mask,
  input  pmask_t         commit_mask,
  input  logic           snap_take,
  input  stag_t          snap_tag,
  input  logic           recover,
  input  stag_t          rec_tag,
  output preg_t          pick0,
  output preg_t          pick1,
  output logic [PW:0]    free_cnt
);
  pmask_t free_q;
  pmask_t since_q [SNAP_N];
  logic   got0, got1;

  // two lowest free entries, found by priority scans
  always_comb begin
    pick0 = '0;
    pick1 = '0;
    got0  = 1'b0;
    got1  = 1'b0;
    for (int p = 0; p < PHYS_N; p++) begin
      if (free_q[p] && !got0) begin
        pick0 = preg_t'(p);
        got0  = 1'b1;
      end else if (free_q[p] && !got1) begin
        pick1 = preg_t'(p);
        got1  = 1'b1;
      end
    end
    free_cnt = (PW+1)'($countones(free_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PHYS_N; p++) free_q[p] <= (p >= ARCH_N);
      for (int s = 0; s < SNAP_N; s++) since_q[s] <= '0;
    end else if (recover) begin
      free_q <= free_q | since_q[rec_tag] | commit_mask;
      for (int s = 0; s < SNAP_N; s++) since_q[s] <= since_q[s] & ~since_q[rec_tag];
    end else begin
      free_q <= (free_q & ~alloc_mask) | commit_mask;
      for (int s = 0; s < SNAP_N; s++) begin
        if (snap_take && stag_t'(s) == snap_tag) since_q[s] <= '0;
        else                                     since_q[s] <= since_q[s] | alloc_mask;
      end
    end
  end
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table import rn_pkg::*; #(
  parameter int RD_N = 3*LANES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  areg_t [RD_N-1:0]        raddr,
  output preg_t [RD_N-1:0]        rdata,
  input  logic  [LANES-1:0]       we,
  input  areg_t [LANES-1:0]       wa,
  input  preg_t [LANES-1:0]       wd,
  input  logic                    snap_take,
  input  stag_t                   snap_tag,
  input  logic                    recover,
  input  stag_t                   rec_tag
);
  map_t tab_q, tab_upd;
  map_t snap_q [SNAP_N];

  for (genvar r = 0; r < RD_N; r++) begin : g_rd
    assign rdata[r] = tab_q[raddr[r]];
  end

  // later lanes overwrite earlier ones
  always_comb begin
    tab_upd = tab_q;
    for (int l = 0; l < LANES; l++)
      if (we[l]) tab_upd[wa[l]] = wd[l];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < ARCH_N; a++) tab_q[a] <= preg_t'(a);
    end else if (recover) begin
      tab_q <= snap_q[rec_tag];
    end else begin
      tab_q <= tab_upd;
    end
  end

  for (genvar s = 0; s < SNAP_N; s++) begin : g_snap
    always_ff @(posedge clk) begin
      if (!recover && snap_take && snap_tag == stag_t'(s)) snap_q[s] <= tab_upd;
    end
  end
endmodule

// File: rtl/rn_snap_ctrl.sv
module rn_snap_ctrl import rn_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take,
  input  logic  rel_valid,
  input  logic  rel_mis,
  input  stag_t rel_tag,
  output stag_t free_tag,
  output logic  full
);
  logic [SNAP_N-1:0] busy_q, release_m, take_m;
  logic [SNAP_N-1:0] young_q [SNAP_N];

  always_comb begin
    free_tag = '0;
    for (int s = SNAP_N-1; s >= 0; s--)
      if (!busy_q[s]) free_tag = stag_t'(s);
    full      = &busy_q;
    take_m    = take ? (SNAP_N'(1) << free_tag) : '0;
    release_m = '0;
    if (rel_valid) begin
      release_m = SNAP_N'(1) << rel_tag;
      if (rel_mis) release_m = release_m | young_q[rel_tag];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      for (int s = 0; s < SNAP_N; s++) young_q[s] <= '0;
    end else begin
      busy_q <= (busy_q & ~release_m) | take_m;
      if (take) begin
        for (int s = 0; s < SNAP_N; s++) begin
          if (stag_t'(s) == free_tag) young_q[s] <= '0;
          else                        young_q[s] <= young_q[s] | take_m;
        end
      end
    end
  end
endmodule

// File: rtl/rn_rename_unit.sv
module rn_rename_unit import rn_pkg::*; (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic  [LANES-1:0]    in_lane_vld,
  input  logic  [LANES-1:0]    in_has_dst,
  input  areg_t [LANES-1:0]    in_dst,
  input  areg_t [LANES-1:0]    in_src1,
  input  areg_t [LANES-1:0]    in_src2,
  input  logic                 in_branch,
  output logic                 out_valid,
  output logic  [LANES-1:0]    out_lane_vld,
  output preg_t [LANES-1:0]    out_pdst,
  output preg_t [LANES-1:0]    out_psrc1,
  output preg_t [LANES-1:0]    out_psrc2,
  output preg_t [LANES-1:0]    out_pold,
  output logic                 out_snap_vld,
  output stag_t                out_snap_tag,
  input  logic  [LANES-1:0]    cm_valid,
  input  preg_t [LANES-1:0]    cm_pold,
  input  logic                 br_valid,
  input  logic                 br_mispredict,
  input  stag_t                br_tag
);
  localparam int RD_N = 3*LANES;

  logic  [LANES-1:0] wr, we;
  logic  [PW:0]      need, free_cnt;
  preg_t             pick0, pick1;
  preg_t [LANES-1:0] newp, pdst_c, psrc1_c, psrc2_c, pold_c;
  areg_t [RD_N-1:0]  raddr;
  preg_t [RD_N-1:0]  rdata;
  pmask_t            alloc_mask, commit_mask;
  logic              recover, snap_full, fire, take;
  stag_t             free_tag;

  assign recover  = br_valid & br_mispredict;
  assign in_ready = !recover && (free_cnt >= need) && !(in_branch && snap_full);
  assign fire     = in_valid & in_ready;
  assign take     = fire & in_branch;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign wr[l]          = in_lane_vld[l] & in_has_dst[l] & (in_dst[l] != '0);
    assign we[l]          = fire & wr[l];
    assign raddr[3*l]     = in_src1[l];
    assign raddr[3*l + 1] = in_src2[l];
    assign raddr[3*l + 2] = in_dst[l];
  end

  // lane results: table read, overridden by older lanes of the same group
  always_comb begin
    need        = '0;
    alloc_mask  = '0;
    commit_mask = '0;
    for (int l = 0; l < LANES; l++) begin
      need    = need + (PW+1)'(wr[l]);
      newp[l] = (l > 0 && wr[0]) ? pick1 : pick0;
      psrc1_c[l] = rdata[3*l];
      psrc2_c[l] = rdata[3*l + 1];
      pold_c[l]  = rdata[3*l + 2];
      for (int j = 0; j < l; j++) begin
        if (wr[j]) begin
          if (in_src1[l] == in_dst[j]) psrc1_c[l] = newp[j];
          if (in_src2[l] == in_dst[j]) psrc2_c[l] = newp[j];
          if (in_dst[l]  == in_dst[j]) pold_c[l]  = newp[j];
        end
      end
      pdst_c[l] = wr[l] ? newp[l] : '0;
      if (!wr[l]) pold_c[l] = '0;
      if (!in_lane_vld[l]) begin
        psrc1_c[l] = '0;
        psrc2_c[l] = '0;
      end
      if (we[l])       alloc_mask[newp[l]]   = 1'b1;
      if (cm_valid[l]) commit_mask[cm_pold[l]] = 1'b1;
    end
  end

  rn_free_list u_free (
    .clk, .rst_n, .alloc_mask, .commit_mask,
    .snap_take(take), .snap_tag(free_tag),
    .recover, .rec_tag(br_tag),
    .pick0, .pick1, .free_cnt
  );

  rn_map_table #(.RD_N(RD_N)) u_map (
    .clk, .rst_n, .raddr, .rdata,
    .we, .wa(in_dst), .wd(newp),
    .snap_take(take), .snap_tag(free_tag),
    .recover, .rec_tag(br_tag)
  );

  rn_snap_ctrl u_snap (
    .clk, .rst_n, .take,
    .rel_valid(br_valid), .rel_mis(br_mispredict), .rel_tag(br_tag),
    .free_tag, .full(snap_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_lane_vld <= '0;
      out_pdst     <= '0;
      out_psrc1    <= '0;
      out_psrc2    <= '0;
      out_pold     <= '0;
      out_snap_vld <= 1'b0;
      out_snap_tag <= '0;
    end else begin
      out_valid <= fire;
      if (fire) begin
        out_lane_vld <= in_lane_vld;
        out_pdst     <= pdst_c;
        out_psrc1    <= psrc1_c;
        out_psrc2    <= psrc2_c;
        out_pold     <= pold_c;
        out_snap_vld <= in_branch;
        out_snap_tag <= in_branch ? free_tag : '0;
      end
    end
  end
endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk import rn_pkg::*; (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic  [LANES-1:0]    in_lane_vld,
  input logic  [LANES-1:0]    in_has_dst,
  input areg_t [LANES-1:0]    in_dst,
  input areg_t [LANES-1:0]    in_src1,
  input logic                 out_valid,
  input preg_t [LANES-1:0]    out_pdst,
  input preg_t [LANES-1:0]    out_psrc1,
  input logic                 br_valid,
  input logic                 br_mispredict
);
  // R11
  stall_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> !out_valid);

  // R2
  accept_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R2
  pdst_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_pdst[0] != '0 && out_pdst[1] != '0) |-> out_pdst[0] != out_pdst[1]);

  // R5
  group_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_lane_vld[0] && in_has_dst[0] && in_dst[0] != '0 &&
                        in_lane_vld[1] && in_src1[1] == in_dst[0]))
    |-> out_psrc1[1] == out_pdst[0]);

  // R6
  zero_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(in_lane_vld[0] && in_dst[0] == '0)) |-> out_pdst[0] == '0);

  // R10
  recover_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_mispredict) |-> !in_ready);
endmodule

bind rn_rename_unit rn_rename_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_lane_vld(in_lane_vld), .in_has_dst(in_has_dst), .in_dst(in_dst),
  .in_src1(in_src1), .out_valid(out_valid), .out_pdst(out_pdst),
  .out_psrc1(out_psrc1), .br_valid(br_valid), .br_mispredict(br_mispredict)
);

// File: tb/tb_rn_rename_unit.sv
module tb_rn_rename_unit;
  import rn_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_branch = 1'b0;
  logic in_ready;
  logic [1:0] in_lane_vld = '0, in_has_dst = '0;
  areg_t [1:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic out_valid, out_snap_vld;
  logic [1:0] out_lane_vld;
  preg_t [1:0] out_pdst, out_psrc1, out_psrc2, out_pold;
  stag_t out_snap_tag;
  logic [1:0] cm_valid = '0;
  preg_t [1:0] cm_pold = '0;
  logic br_valid = 1'b0, br_mispredict = 1'b0;
  stag_t br_tag = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rn_rename_unit dut (.*);

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [36:0] exp_q[$];
  string rq_q[$];

  // reference state
  int m_tab[8];
  logic [15:0] m_free;
  int m_snap[4][8];
  logic [3:0] m_busy;
  logic [15:0] m_since[4];
  logic [3:0] m_young[4];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic int lowest(input logic [15:0] m, input int skip);
    for (int p = 0; p < 16; p++) if (m[p] && p != skip) return p;
    return -1;
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      logic [36:0] act;
      act = {out_lane_vld, out_pdst, out_psrc1, out_psrc2, out_pold, out_snap_vld, out_snap_tag};
      if (exp_q.size() == 0) chk(0, "R11", "unexpected group", 64'(act), 0);
      else begin
        logic [36:0] e;
        string r;
        e = exp_q.pop_front();
        r = rq_q.pop_front();
        chk(act == e, r, "renamed group", 64'(act), 64'(e));
      end
    end
  end

  task automatic send(input logic [1:0] lv, input logic [1:0] hd, input logic [5:0] d,
                      input logic [5:0] s1, input logic [5:0] s2, input logic br,
                      input string rq);
    int dd[2], a1[2], a2[2], pd[2], p1[2], p2[2], po[2], np[2];
    bit w[2];
    int need, fcnt, tg;
    bit stall;
    @(negedge clk);
    in_valid = 1'b1; in_lane_vld = lv; in_has_dst = hd; in_branch = br;
    in_dst = d; in_src1 = s1; in_src2 = s2;
    for (int l = 0; l < 2; l++) begin
      dd[l] = int'(d[3*l +: 3]); a1[l] = int'(s1[3*l +: 3]); a2[l] = int'(s2[3*l +: 3]);
      w[l] = lv[l] && hd[l] && dd[l] != 0;
    end
    need = int'(w[0]) + int'(w[1]);
    fcnt = $countones(m_free);
    stall = (need > fcnt) || (br && (&m_busy));
    #1;
    chk(in_ready == !stall, rq, "in_ready", 64'(in_ready), 64'(!stall));
    if (!stall) begin
      np[0] = lowest(m_free, -1);
      np[1] = w[0] ? lowest(m_free, np[0]) : np[0];
      for (int l = 0; l < 2; l++) begin
        p1[l] = m_tab[a1[l]]; p2[l] = m_tab[a2[l]]; po[l] = m_tab[dd[l]];
        if (l == 1 && w[0]) begin
          if (a1[1] == dd[0]) p1[1] = np[0];
          if (a2[1] == dd[0]) p2[1] = np[0];
          if (dd[1] == dd[0]) po[1] = np[0];
        end
        pd[l] = w[l] ? np[l] : 0;
        if (!w[l]) po[l] = 0;
        if (!lv[l]) begin p1[l] = 0; p2[l] = 0; end
      end
      for (int l = 0; l < 2; l++) if (w[l]) begin
        m_tab[dd[l]] = np[l];
        m_free[np[l]] = 1'b0;
        for (int s = 0; s < 4; s++) m_since[s][np[l]] = 1'b1;
      end
      tg = 0;
      if (br) begin
        tg = lowest({12'd0, ~m_busy}, -1);
        m_snap[tg] = m_tab;
        m_since[tg] = '0;
        for (int s = 0; s < 4; s++) if (s != tg) m_young[s][tg] = 1'b1;
        m_young[tg] = '0;
        m_busy[tg] = 1'b1;
      end
      exp_q.push_back({lv, 4'(pd[1]), 4'(pd[0]), 4'(p1[1]), 4'(p1[0]), 4'(p2[1]), 4'(p2[0]),
                       4'(po[1]), 4'(po[0]), br, 2'(tg)});
      rq_q.push_back(rq);
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_lane_vld = '0; in_has_dst = '0; in_branch = 1'b0;
  endtask

  task automatic commit(input logic [1:0] v, input int pa, input int pb);
    @(negedge clk);
    cm_valid = v; cm_pold[0] = preg_t'(pa); cm_pold[1] = preg_t'(pb);
    if (v[0]) m_free[pa] = 1'b1;
    if (v[1]) m_free[pb] = 1'b1;
    @(posedge clk); #1;
    cm_valid = '0;
  endtask

  task automatic resolve(input int t, input bit mis);
    logic [15:0] gone;
    @(negedge clk);
    br_valid = 1'b1; br_mispredict = mis; br_tag = stag_t'(t);
    #1;
    if (mis) chk(in_ready == 1'b0, "R10", "in_ready during recovery", 64'(in_ready), 0);
    if (mis) begin
      gone = m_since[t];
      m_tab = m_snap[t];
      m_free = m_free | gone;
      for (int s = 0; s < 4; s++) m_since[s] = m_since[s] & ~gone;
      m_busy = m_busy & ~(m_young[t] | (4'd1 << t));
    end else m_busy[t] = 1'b0;
    @(posedge clk); #1;
    br_valid = 1'b0; br_mispredict = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      chk(0, "R1", "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 8; a++) m_tab[a] = a;
    m_free = 16'hFF00; m_busy = '0;
    for (int s = 0; s < 4; s++) begin m_since[s] = '0; m_young[s] = '0; end
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 1);
    rst_n = 1'b1;
    // R2 R3 R5: lane1 reads lane0 destination
    send(2'b11, 2'b11, {3'd3, 3'd1}, {3'd1, 3'd3}, {3'd2, 3'd2}, 1'b0, "R5");
    // R5: both lanes write r5, lane1 reads r5
    send(2'b11, 2'b11, {3'd5, 3'd5}, {3'd5, 3'd4}, {3'd1, 3'd6}, 1'b0, "R5");
    // R6: lane0 targets r0, lane1 writes r4
    send(2'b11, 2'b11, {3'd4, 3'd0}, {3'd0, 3'd7}, {3'd3, 3'd0}, 1'b0, "R6");
    // R4: only lane1 valid
    send(2'b10, 2'b10, {3'd7, 3'd2}, {3'd3, 3'd5}, {3'd1, 3'd6}, 1'b0, "R4");
    // R3: lane0 reads renamed registers, non-writing lane1
    send(2'b11, 2'b01, {3'd2, 3'd6}, {3'd5, 3'd1}, {3'd7, 3'd3}, 1'b0, "R3");
    // R7: one register left, two needed
    send(2'b11, 2'b11, {3'd1, 3'd2}, {3'd1, 3'd1}, {3'd1, 3'd1}, 1'b0, "R7");
    send(2'b01, 2'b01, {3'd0, 3'd1}, {3'd0, 3'd4}, {3'd0, 3'd5}, 1'b0, "R7");
    send(2'b01, 2'b01, {3'd0, 3'd2}, {3'd0, 3'd4}, {3'd0, 3'd5}, 1'b0, "R7");
    send(2'b11, 2'b00, {3'd1, 3'd1}, {3'd2, 3'd3}, {3'd4, 3'd5}, 1'b0, "R7");
    send(2'b00, 2'b00, 6'd0, 6'd0, 6'd0, 1'b0, "R4");
    // R8: return displaced registers 1 and 3, then reuse them
    commit(2'b11, 1, 3);
    send(2'b11, 2'b11, {3'd6, 3'd3}, {3'd3, 3'd6}, {3'd2, 3'd1}, 1'b0, "R8");
    commit(2'b11, 5, 4);
    // R9 R10: checkpoint, speculative write, mispredict
    send(2'b01, 2'b01, {3'd0, 3'd2}, {3'd0, 3'd6}, {3'd0, 3'd2}, 1'b1, "R9");
    send(2'b01, 2'b01, {3'd0, 3'd6}, {3'd0, 3'd2}, {3'd0, 3'd6}, 1'b0, "R10");
    resolve(0, 1'b1);
    send(2'b11, 2'b01, {3'd0, 3'd7}, {3'd2, 3'd6}, {3'd6, 3'd2}, 1'b0, "R10");
    // R9: fill all slots, fifth branch refused
    for (int k = 0; k < 4; k++) send(2'b01, 2'b00, 6'd0, 6'd9, 6'd0, 1'b1, "R9");
    send(2'b01, 2'b00, 6'd0, 6'd9, 6'd0, 1'b1, "R9");
    resolve(1, 1'b0);
    send(2'b01, 2'b00, 6'd0, 6'd9, 6'd0, 1'b1, "R9");
    resolve(0, 1'b1);
    send(2'b01, 2'b00, 6'd0, 6'd9, 6'd0, 1'b1, "R10");
    repeat (3) @(posedge clk);
    #1;
    chk(exp_q.size() == 0, "R2", "groups left unseen", 64'(exp_q.size()), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule